// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block holds the configuration and status state of a serial nonvolatile memory and decides whether a write is allowed. It keeps a write-enable latch, a two-bit protection level and a lock-enable bit. It also exposes a status byte for a read-status command. The serial front end sends one-cycle strobes for three commands: set latch, clear latch, and status byte received. It also passes the chip-select level. The array programmer supplies a busy level and a one-cycle completion pulse. The write-lock pin level comes straight from the board.

For any target address the block states, in the same cycle, whether the array location may be written. It also states whether a status write may be accepted. A status byte received from the front end is staged. The byte takes effect only when chip select rises. Before that point, if the hardware lock becomes active, the staged byte is dropped. The protection level and lock-enable bit simply keep their state across cycles; the stored value stands in for nonvolatile storage.

All interfaces are plain control and status pins. No data stream crosses the block's edge, so the block has no valid/ready handshake and no back-pressure.

Top module: `swg_top`

## Requirements
- R1: After reset the write-enable latch is 0, the lock-enable bit is 0 and the protection level is 00. The status byte reads 0x00 and both permission outputs are 0.
- R2: A `set_wel_stb` pulse sets the write-enable latch. A `clr_wel_stb` pulse clears it, whatever the level of `wr_lock_n`. If both pulses arrive in the same cycle, the clear wins.
- R3: A `cycle_done` pulse clears the write-enable latch.
- R4: While `busy` is 1, `status_byte` reads 0xFF and both permission outputs are 0. The set, clear and status-byte strobes are ignored during this time.
- R5: When idle, the status byte holds the following fields:
  - bit 7: lock-enable
  - bits 6..4: 0
  - bits 3..2: protection level (bit 3 is the high bit)
  - bit 1: write-enable latch
  - bit 0: 0 (busy flag)
- R6: The protection level picks the protected range from the two top address bits. Level 00 protects nothing. Level 01 protects addresses whose top two bits are 11 (top quarter). Level 10 protects addresses whose top bit is 1 (top half). Level 11 protects every address. `arr_wr_ok` is 1 only when the latch is 1, the block is not busy and the address is outside the range.
- R7: The hardware lock is active only when `wr_lock_n` is 0 and lock-enable is 1. `sr_wr_ok` is 1 only when the latch is 1, the block is not busy and the lock is inactive.
- R8: A `sr_byte_stb` is accepted only while `sr_wr_ok` is 1. The accepted byte is applied on the next rising edge of `sel_n`. Only bit 7 (lock-enable) and bits 3..2 (level) are taken. Applying the byte leaves the latch unchanged.
- R9: A staged status byte is discarded if the hardware lock becomes active before `sel_n` rises. In that case nothing changes when `sel_n` rises.
- R10: A `sr_byte_stb` that is not accepted has no effect. This covers a strobe with the latch clear and a strobe while the hardware lock is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Chip-select level, low while a command is in progress |
| set_wel_stb | input | 1 | Set-latch command strobe |
| clr_wel_stb | input | 1 | Clear-latch command strobe |
| sr_byte_stb | input | 1 | A complete status data byte has arrived |
| sr_byte | input | 8 | The status data byte |
| wr_lock_n | input | 1 | Write-lock pin level, active low |
| busy | input | 1 | Internal write cycle in progress |
| cycle_done | input | 1 | One-cycle pulse when a write cycle ends |
| addr | input | ADDR_W | Target array address |
| arr_wr_ok | output | 1 | Array write at `addr` allowed |
| sr_wr_ok | output | 1 | Status write allowed |
| status_byte | output | 8 | Byte returned by a read-status command |

## Verification
The main permission function is swept over every protection level and both lock-enable values. For each setting, the address probes sit on both sides of the quarter and half boundaries, which separates the three range shapes from one another. Each setting is also tried with the lock pin high and low, which distinguishes a lock that depends on the pin alone from one that also needs lock-enable. Directed sequences cover the following cases:
- a staged byte aborted by the lock pin, against one committed normally;
- a byte rejected at the strobe;
- clearing the latch under the lock pin;
- a busy window.

Together these separate the stage-and-commit path from an immediate write.

// File: rtl/swg_pkg.sv
package swg_pkg;
  localparam int STAT_W  = 8;
  localparam int LVL_W   = 2;
  localparam int BIT_LEN = 7;
  localparam int BIT_LVH = 3;
  localparam int BIT_LVL = 2;
  localparam int BIT_WEL = 1;

  typedef struct packed {
    logic             lock_en;
    logic [LVL_W-1:0] level;
  } swg_cfg_t;

  function automatic logic [STAT_W-1:0] swg_pack(input logic busy,
                                                 input swg_cfg_t cfg,
                                                 input logic wel);
    logic [STAT_W-1:0] s;
    s = '0;
    if (busy) begin
      s = '1;
    end else begin
      s[BIT_LEN] = cfg.lock_en;
      s[BIT_LVH:BIT_LVL] = cfg.level;
      s[BIT_WEL] = wel;
    end
    return s;
  endfunction
endpackage

// File: rtl/swg_range_decode.sv
module swg_range_decode #(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range
);
  localparam int TOP = ADDR_W - 1;
  localparam int NXT = ADDR_W - 2;

  always_comb begin
    unique case (level)
      2'b00: in_range = 1'b0;
      2'b01: in_range = addr[TOP] & addr[NXT];
      2'b10: in_range = addr[TOP];
      default: in_range = 1'b1;
    endcase
  end
endmodule

// File: rtl/swg_wrsr_stage.sv
module swg_wrsr_stage
  import swg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              arm_stb,
  input  logic [STAT_W-1:0] arm_byte,
  input  logic              arm_ok,
  input  logic              hw_lock,
  output logic              commit,
  output swg_cfg_t          commit_cfg
);
  logic     sel_q;
  logic     pend_q;
  swg_cfg_t pend_cfg_q;
  logic     sel_rise;

  assign sel_rise = ~sel_q & sel_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= 1'b1;
      pend_q     <= 1'b0;
      pend_cfg_q <= '0;
    end else begin
      sel_q <= sel_n;
      if (sel_rise) begin
        pend_q <= 1'b0;
      end else if (arm_stb && arm_ok) begin
        pend_q             <= 1'b1;
        pend_cfg_q.lock_en <= arm_byte[BIT_LEN];
        pend_cfg_q.level   <= arm_byte[BIT_LVH:BIT_LVL];
      end else if (hw_lock) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign commit     = sel_rise & pend_q;
  assign commit_cfg = pend_cfg_q;

  // R9
  wp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |=> !pend_q);

  // R8
  commit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(sel_n) == 1'b0) && sel_n);
endmodule

// File: rtl/swg_status_core.sv
module swg_status_core
  import swg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_stb,
  input  logic     clr_stb,
  input  logic     busy,
  input  logic     cycle_done,
  input  logic     commit,
  input  swg_cfg_t commit_cfg,
  output logic     wel,
  output swg_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel <= 1'b0;
      cfg <= '0;
    end else begin
      if (cycle_done) begin
        wel <= 1'b0;
      end else if (!busy) begin
        if (clr_stb)      wel <= 1'b0;
        else if (set_stb) wel <= 1'b1;
      end
      if (commit) cfg <= commit_cfg;
    end
  end

  // R2
  wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(set_stb) && !$past(clr_stb) && !$past(busy));

  // R3
  wel_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !wel);

  // R8
  cfg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(commit));
endmodule

// File: rtl/swg_top.sv
module swg_top
  import swg_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              set_wel_stb,
  input  logic              clr_wel_stb,
  input  logic              sr_byte_stb,
  input  logic [7:0]        sr_byte,
  input  logic              wr_lock_n,
  input  logic              busy,
  input  logic              cycle_done,
  input  logic [ADDR_W-1:0] addr,
  output logic              arr_wr_ok,
  output logic              sr_wr_ok,
  output logic [7:0]        status_byte
);
  logic     wel;
  swg_cfg_t cfg;
  logic     hw_lock;
  logic     in_range;
  logic     commit;
  swg_cfg_t commit_cfg;

  assign hw_lock   = cfg.lock_en & ~wr_lock_n;
  assign sr_wr_ok  = wel & ~busy & ~hw_lock;
  assign arr_wr_ok = wel & ~busy & ~in_range;
  assign status_byte = swg_pack(busy, cfg, wel);

  swg_range_decode #(.ADDR_W(ADDR_W)) u_range (
    .level    (cfg.level),
    .addr     (addr),
    .in_range (in_range)
  );

  swg_wrsr_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .arm_stb    (sr_byte_stb),
    .arm_byte   (sr_byte),
    .arm_ok     (sr_wr_ok),
    .hw_lock    (hw_lock),
    .commit     (commit),
    .commit_cfg (commit_cfg)
  );

  swg_status_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_stb    (set_wel_stb),
    .clr_stb    (clr_wel_stb),
    .busy       (busy),
    .cycle_done (cycle_done),
    .commit     (commit),
    .commit_cfg (commit_cfg),
    .wel        (wel),
    .cfg        (cfg)
  );

  // R6
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11 && !busy) |-> !arr_wr_ok);

  // R7
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lock_n && status_byte[7] && !busy) |-> !sr_wr_ok);

  // R4
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !arr_wr_ok && !sr_wr_ok && status_byte == 8'hFF);
endmodule

// File: tb/swg_top_bench.sv
module swg_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic set_wel_stb = 1'b0, clr_wel_stb = 1'b0, sr_byte_stb = 1'b0;
  logic [7:0] sr_byte = 8'h00;
  logic wr_lock_n = 1'b1;
  logic busy = 1'b0, cycle_done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic arr_wr_ok, sr_wr_ok;
  logic [7:0] status_byte;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swg_top #(.ADDR_W(AW)) u_swg_top (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n),
    .set_wel_stb(set_wel_stb), .clr_wel_stb(clr_wel_stb),
    .sr_byte_stb(sr_byte_stb), .sr_byte(sr_byte),
    .wr_lock_n(wr_lock_n), .busy(busy), .cycle_done(cycle_done),
    .addr(addr), .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok),
    .status_byte(status_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_set();
    @(negedge clk); set_wel_stb = 1'b1;
    @(negedge clk); set_wel_stb = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_wel_stb = 1'b1;
    @(negedge clk); clr_wel_stb = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); cycle_done = 1'b1;
    @(negedge clk); cycle_done = 1'b0;
  endtask

  // select, deliver one status byte, optionally drop the lock pin, deselect
  task automatic send_sr(input logic [7:0] b, input bit drop_lock);
    @(negedge clk); sel_n = 1'b0;
    @(negedge clk); sr_byte_stb = 1'b1; sr_byte = b;
    @(negedge clk); sr_byte_stb = 1'b0;
    if (drop_lock) begin
      wr_lock_n = 1'b0;
      @(negedge clk);
    end
    @(negedge clk); sel_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic exp_prot(input int lv, input logic [AW-1:0] a);
    int aa;
    aa = int'(a);
    if (lv == 3) return 1'b1;
    if (lv == 2) return aa >= (1 << (AW-1));
    if (lv == 1) return aa >= (3 << (AW-2));
    return 1'b0;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status_byte, 8'h00);
    chk("R1 arr_ok", arr_wr_ok, 0);
    chk("R1 sr_ok", sr_wr_ok, 0);

    // R10 status byte without latch is ignored
    send_sr(8'h8C, 1'b0);
    chk("R10 no latch", status_byte, 8'h00);

    // R2 set then clear, clear wins
    pulse_set();
    chk("R2 set", status_byte, 8'h02);
    @(negedge clk); set_wel_stb = 1'b1; clr_wel_stb = 1'b1;
    @(negedge clk); set_wel_stb = 1'b0; clr_wel_stb = 1'b0;
    chk("R2 clear wins", status_byte, 8'h00);

    // R6 R7 R5 R8 sweep of level, lock-enable, address and lock pin
    for (int lv = 0; lv < 4; lv++) begin
      for (int le = 0; le < 2; le++) begin
        wr_lock_n = 1'b1;
        pulse_set();
        send_sr({le[0], 3'b111, lv[1:0], 2'b11}, 1'b0);
        chk("R5 R8 status fields", status_byte, {le[0], 3'b000, lv[1:0], 2'b10});
        for (int q = 0; q < 8; q++) begin
          for (int e = 0; e < 2; e++) begin
            @(negedge clk);
            addr = AW'((q << (AW-3)) + e * ((1 << (AW-3)) - 1));
            #1;
            chk("R6 arr_ok", arr_wr_ok, !exp_prot(lv, addr));
          end
        end
        for (int w = 0; w < 2; w++) begin
          @(negedge clk); wr_lock_n = w[0]; #1;
          chk("R7 sr_ok", sr_wr_ok, !(le == 1 && w == 0));
        end
        wr_lock_n = 1'b1;
        pulse_done();
        chk("R3 done clears latch", status_byte[1], 0);
        @(negedge clk); addr = '0; #1;
        chk("R6 no latch", arr_wr_ok, 0);
      end
    end

    // R9 abort: lock-enable set, then staged byte dropped by the lock pin
    wr_lock_n = 1'b1;
    pulse_set();
    send_sr(8'h84, 1'b0);
    chk("R8 setup", status_byte, 8'h86);
    send_sr(8'h00, 1'b1);
    chk("R9 abort", status_byte, 8'h86);

    // R10 rejected while locked
    send_sr(8'h0C, 1'b0);
    chk("R10 locked", status_byte, 8'h86);

    // R2 clear works with lock pin low
    pulse_clr();
    chk("R2 clear under lock", status_byte, 8'h84);
    wr_lock_n = 1'b1;

    // R4 busy window
    pulse_set();
    @(negedge clk); busy = 1'b1; #1;
    chk("R4 status ff", status_byte, 8'hFF);
    chk("R4 arr_ok", arr_wr_ok, 0);
    chk("R4 sr_ok", sr_wr_ok, 0);
    pulse_clr();
    @(negedge clk); busy = 1'b0; #1;
    chk("R4 clear ignored", status_byte, 8'h86);
    pulse_done();
    chk("R3 done", status_byte, 8'h84);
    @(negedge clk); busy = 1'b1;
    pulse_set();
    @(negedge clk); busy = 1'b0; #1;
    chk("R4 set ignored", status_byte, 8'h84);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule